// File: doc/BRIEF.md
# Buffered PWM Timer with Edge and Centre Alignment

This block is a single-channel pulse-width modulator built around a prescaled counter. An internal divider turns the input clock into count ticks, and a counter walks between zero and a programmable period limit. The counter can run as a rising sawtooth that restarts from zero, or as a triangle that climbs to the limit and falls back. One compare threshold sets the duty cycle. The polarity is selectable: the output can be active while the count is under the threshold, or active from the threshold upward.

The divider setting always waits for an update event. The period limit and the compare threshold can be written straight to their working copies, or into holding registers that are copied over only at the next update event. With buffering turned on, software can change duty and period at any time without producing a short or stretched pulse. An update event happens when the counter wraps, at each end of the triangle, or when software writes the force-update command. It raises a sticky flag and, if enabled, an interrupt request. There are also one-cycle pulses for update and for compare match.

The counter is controlled by a small state machine with three states. `CNT_IDLE` holds the count while the run bit is clear. `CNT_UP` increments. `CNT_DOWN` decrements and is used only for the triangle. The transitions are:
- run set: `CNT_IDLE` to `CNT_UP`.
- run cleared: `CNT_UP` or `CNT_DOWN` to `CNT_IDLE`.
- top reached in triangle mode: `CNT_UP` to `CNT_DOWN`.
- zero reached going down: `CNT_DOWN` to `CNT_UP`.
- triangle mode switched off: `CNT_DOWN` to `CNT_UP`.
- force update: any state to `CNT_UP`, or to `CNT_IDLE` if not running.

Register map for `wr_addr`:
- 0, control: bit0 run, bit1 triangle mode, bit2 inverted polarity, bit3 compare buffering, bit4 period buffering, bit5 interrupt enable.
- 1, divider.
- 2, period limit.
- 3, compare threshold.
- 4, command: bit0 force update, bit1 clear flag. These are strobes and are not stored.

Top module: `pwm_timer`

## Requirements
- R1: The divider value D makes the counter advance once every D+1 clocks. A written D takes effect only at the next update event.
- R2: In sawtooth mode the count runs 0,1,…,P and then returns to 0. This gives P+1 ticks per period. `upd_pulse` is high for one cycle, the first cycle in which the count reads 0 after the wrap.
- R3: Control bit2 = 0 makes `pwm_out` high while count < C. Bit2 = 1 makes it high while count >= C.
- R4: With bit2 = 0, C = 0 keeps `pwm_out` low all the time. Any C >= P+1 keeps it high all the time.
- R5: With control bit3 set, a threshold write does not change the output until the next update event. With bit3 clear, it takes effect on the next cycle.
- R6: With control bit4 set, a period write takes effect at the next update event. With bit4 clear, it takes effect on the next cycle.
- R7: A buffered write landing on the same clock edge as an update event is held. The working copy takes the previous held value, and the new value arrives at the following update event.
- R8: In triangle mode (control bit1) the count goes 0,1,…,P,P−1,…,1,0,1… with a period of 2P ticks. An update event occurs on leaving P and on leaving 0 while going down.
- R9: `cmp_pulse` is high for one cycle when the counter steps onto the value C.
- R10: `upd_flag` is set by every update event and stays set until command bit1 clears it. `irq` is high exactly while the flag and control bit5 are both set.
- R11: Command bit0 sets count and divider phase to 0, loads all held values into the working copies, and raises an update event.
- R12: After reset the count is 0, `pwm_out` is low, and `upd_flag`, `irq`, `upd_pulse` and `cmp_pulse` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | 1 | Modulated output |
| cnt_value | output | CNT_W | Current counter value |
| upd_pulse | output | 1 | One-cycle pulse after an update event |
| cmp_pulse | output | 1 | One-cycle pulse when the counter steps onto the threshold |
| upd_flag | output | 1 | Sticky update flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench writes a threshold one cycle into a period with buffering on. A design that did not buffer would lower the output too early, or raise it too soon, in that same period. The bench also aims a write exactly at the wrap edge. A design that copied the freshly written value at that edge would show the new duty one period early.

The divider is rewritten while running. A design that applied the new value at once would slow the count before the wrap.

The triangle is traced through both turning points. An off-by-one there would make the period 2P±1, or would place the update pulse at the wrong extreme.

The bench also covers several other cases:
- Thresholds of 0, P+1 and all-ones, to catch a comparison that uses <= or that wraps.
- Polarity inversion.
- Force update in the middle of a divided tick, which must restart the divider phase.
- Flag clearing, to catch a flag that drops on its own or an interrupt that ignores its enable.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    typedef enum logic [1:0] {
        CNT_IDLE = 2'd0,
        CNT_UP   = 2'd1,
        CNT_DOWN = 2'd2
    } cnt_state_e;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] REG_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] REG_DIV    = 3'd1;
    localparam logic [ADDR_W-1:0] REG_PERIOD = 3'd2;
    localparam logic [ADDR_W-1:0] REG_CMP    = 3'd3;
    localparam logic [ADDR_W-1:0] REG_CMD    = 3'd4;

    localparam int unsigned CTRL_W = 6;

    // Field order matches control bits 5..0.
    typedef struct packed {
        logic irq_en;
        logic per_buf;
        logic cmp_buf;
        logic invert;
        logic center;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
    parameter int unsigned W = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         buffered,
    input  logic         load,
    output logic [W-1:0] active_o
);

    logic [W-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q   <= RST_VAL;
            active_o <= RST_VAL;
        end else begin
            if (wr_en) begin
                held_q <= wr_data;
            end
            if (wr_en && !buffered) begin
                active_o <= wr_data;
            end else if (load) begin
                active_o <= held_q;
            end
        end
    end

    // R5 (compare) and R6 (period): buffered working copy moves only at an update
    a_r5_buffered_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (buffered && !load) |=> $stable(active_o));

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] divisor,
    output logic         tick_o
);

    logic [W-1:0] phase_q;

    assign tick_o = run && (phase_q == divisor);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= tick_o ? '0 : phase_q + 1'b1;
        end
    end

    // R1: the phase never runs past the working divider value
    a_r1_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= divisor);

    // R11: a forced update restarts the divider phase
    a_r11_phase_clear: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase_q == '0));

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_timer_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         center,
    input  logic         tick,
    input  logic         force_upd,
    input  logic [W-1:0] period,
    output logic [W-1:0] count_o,
    output logic         uev_o,
    output logic         step_o
);

    cnt_state_e state_q, state_n;
    logic [W-1:0] count_n;
    logic at_top, at_bottom;

    // Output process: events derived from the current state
    always_comb begin
        at_top    = 1'b0;
        at_bottom = 1'b0;
        step_o    = 1'b0;
        unique case (state_q)
            CNT_IDLE: ;
            CNT_UP: begin
                step_o = run && tick && !force_upd;
                at_top = step_o && (count_o == period);
            end
            CNT_DOWN: begin
                step_o    = run && tick && !force_upd && center;
                at_bottom = step_o && (count_o == '0);
            end
            default: ;
        endcase
        uev_o = force_upd || at_top || at_bottom;
    end

    // Next-state process
    always_comb begin
        state_n = state_q;
        count_n = count_o;
        if (force_upd) begin
            state_n = run ? CNT_UP : CNT_IDLE;
            count_n = '0;
        end else begin
            unique case (state_q)
                CNT_IDLE: begin
                    if (run) state_n = CNT_UP;
                end
                CNT_UP: begin
                    if (!run) begin
                        state_n = CNT_IDLE;
                    end else if (at_top) begin
                        if (center) begin
                            state_n = CNT_DOWN;
                            count_n = period - 1'b1;
                        end else begin
                            count_n = '0;
                        end
                    end else if (step_o) begin
                        count_n = count_o + 1'b1;
                    end
                end
                CNT_DOWN: begin
                    if (!run) begin
                        state_n = CNT_IDLE;
                    end else if (!center) begin
                        state_n = CNT_UP;
                    end else if (at_bottom) begin
                        state_n = CNT_UP;
                        count_n = count_o + 1'b1;
                    end else if (step_o) begin
                        count_n = count_o - 1'b1;
                    end
                end
                default: state_n = CNT_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_IDLE;
            count_o <= '0;
        end else begin
            state_q <= state_n;
            count_o <= count_n;
        end
    end

    // R2: sawtooth returns to zero after the limit
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_UP && run && tick && !center && !force_upd && count_o == period)
        |=> (count_o == '0));

    // R11: forced update clears the count
    a_r11_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
        force_upd |=> (count_o == '0));

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              pwm_out,
    output logic [CNT_W-1:0]  cnt_value,
    output logic              upd_pulse,
    output logic              cmp_pulse,
    output logic              upd_flag,
    output logic              irq
);

    localparam logic [CNT_W-1:0] PERIOD_RST = '1;

    ctrl_t            ctrl_q;
    logic             force_upd, clr_flag;
    logic             uev, tick, step, moved_q;
    logic [CNT_W-1:0] div_act, per_act, cmp_act;

    assign force_upd = wr_en && (wr_addr == REG_CMD) && wr_data[0];
    assign clr_flag  = wr_en && (wr_addr == REG_CMD) && wr_data[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && wr_addr == REG_CTRL) begin
            ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    pwm_shadow_reg #(.W(CNT_W), .RST_VAL('0)) u_div (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en && wr_addr == REG_DIV), .wr_data(wr_data),
        .buffered(1'b1), .load(uev), .active_o(div_act));

    pwm_shadow_reg #(.W(CNT_W), .RST_VAL(PERIOD_RST)) u_period (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en && wr_addr == REG_PERIOD), .wr_data(wr_data),
        .buffered(ctrl_q.per_buf), .load(uev), .active_o(per_act));

    pwm_shadow_reg #(.W(CNT_W), .RST_VAL('0)) u_cmp (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en && wr_addr == REG_CMP), .wr_data(wr_data),
        .buffered(ctrl_q.cmp_buf), .load(uev), .active_o(cmp_act));

    pwm_prescaler #(.W(CNT_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q.run),
        .restart(force_upd), .divisor(div_act), .tick_o(tick));

    pwm_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .center(ctrl_q.center),
        .tick(tick), .force_upd(force_upd), .period(per_act),
        .count_o(cnt_value), .uev_o(uev), .step_o(step));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_flag  <= 1'b0;
            upd_pulse <= 1'b0;
            moved_q   <= 1'b0;
        end else begin
            upd_pulse <= uev;
            moved_q   <= step;
            if (uev) begin
                upd_flag <= 1'b1;
            end else if (clr_flag) begin
                upd_flag <= 1'b0;
            end
        end
    end

    assign pwm_out   = ctrl_q.invert ^ (cnt_value < cmp_act);
    assign cmp_pulse = moved_q && (cnt_value == cmp_act);
    assign irq       = upd_flag && ctrl_q.irq_en;

    // R10: the flag stays set until explicitly cleared
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_flag && !clr_flag) |=> upd_flag);

endmodule

// File: tb/pwm_timer_tb.sv
module pwm_timer_tb;

    localparam int unsigned W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         pwm_out, upd_pulse, cmp_pulse, upd_flag, irq;
    logic [W-1:0] cnt_value;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pwm;
        logic         upd;
        logic         cmp;
    } exp_t;

    exp_t  sb_q[$];
    string tag_q[$];

    pwm_timer #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .cnt_value(cnt_value),
        .upd_pulse(upd_pulse), .cmp_pulse(cmp_pulse), .upd_flag(upd_flag),
        .irq(irq));

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: samples 2 ns after each rising edge and pops the scoreboard
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t  e;
            exp_t  a;
            string t;
            e = sb_q.pop_front();
            t = tag_q.pop_front();
            a = '{cnt: cnt_value, pwm: pwm_out, upd: upd_pulse, cmp: cmp_pulse};
            chk(t, 32'(a), 32'(e));
        end
    end

    task automatic push(input string t, input int c, input bit p, input bit u, input bit m);
        exp_t e;
        e = '{cnt: W'(c), pwm: p, upd: u, cmp: m};
        sb_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [W-1:0] cw(input bit run, input bit ctr, input bit inv,
                                        input bit cbuf, input bit pbuf, input bit ie);
        return W'({ie, pbuf, cbuf, inv, ctr, run});
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        chk("R12 cnt", 32'(cnt_value), 0);
        chk("R12 pwm", 32'(pwm_out), 0);
        chk("R12 flag", 32'(upd_flag), 0);
        chk("R12 irq", 32'(irq), 0);
        chk("R12 pulses", 32'({upd_pulse, cmp_pulse}), 0);

        // R2 / R3 / R9 sawtooth, threshold 2, limit 4
        wr(1, 0); wr(2, 4); wr(3, 2); wr(0, cw(1,0,0,0,0,0));
        wr(4, 1);
        for (int k = 1; k <= 12; k++)
            push("R2 sawtooth", k % 5, (k % 5) < 2, (k % 5) == 0, (k % 5) == 2);
        step(12);

        // R3 inverted polarity
        wr(0, cw(1,0,1,0,0,0));
        wr(4, 1);
        for (int k = 1; k <= 10; k++)
            push("R3 inverted", k % 5, !((k % 5) < 2), (k % 5) == 0, (k % 5) == 2);
        step(10);

        // R4 threshold extremes
        wr(0, cw(1,0,0,0,0,0));
        wr(3, 0);
        for (int i = 0; i < 6; i++) begin chk("R4 cmp0 low", 32'(pwm_out), 0); step(1); end
        wr(3, 5);
        for (int i = 0; i < 6; i++) begin chk("R4 cmp P+1 high", 32'(pwm_out), 1); step(1); end
        wr(3, 16'hFFFF);
        for (int i = 0; i < 3; i++) begin chk("R4 cmp max high", 32'(pwm_out), 1); step(1); end

        // R5 buffered threshold
        wr(0, cw(1,0,0,1,0,0));
        wr(3, 2);
        wr(4, 1);           // k=0
        wr(3, 4);           // k=1
        step(2);            // k=3
        chk("R5 held cnt", 32'(cnt_value), 3);
        chk("R5 held old duty", 32'(pwm_out), 0);
        step(5);            // k=8
        chk("R5 new duty after update", 32'(pwm_out), 1);
        // R5 unbuffered: immediate
        wr(0, cw(1,0,0,0,0,0));
        wr(3, 5);
        chk("R5 unbuffered immediate", 32'(pwm_out), 1);

        // R7 write on the update edge
        wr(0, cw(1,0,0,1,0,0));
        wr(3, 2);
        wr(4, 1);           // k=0
        step(4);            // k=4
        wr(3, 4);           // lands on edge 5, k=5
        step(3);            // k=8
        chk("R7 cnt", 32'(cnt_value), 3);
        chk("R7 previous held value used", 32'(pwm_out), 0);
        step(5);            // k=13
        chk("R7 new value next update", 32'(pwm_out), 1);

        // R6 buffered period
        wr(0, cw(1,0,0,0,1,0));
        wr(3, 2);
        wr(2, 4);
        wr(4, 1);           // k=0
        wr(2, 2);           // k=1
        step(3);            // k=4
        chk("R6 buffered old period", 32'(cnt_value), 4);
        step(4);            // k=8
        chk("R6 new period after update", 32'(cnt_value), 0);
        wr(0, cw(1,0,0,0,0,0));
        wr(2, 4);
        wr(4, 1);           // k=0
        wr(2, 2);           // k=1
        step(2);            // k=3
        chk("R6 unbuffered immediate", 32'(cnt_value), 0);

        // R1 divider buffered, then divide by 3
        wr(2, 4);
        wr(1, 0);
        wr(4, 1);           // k=0
        wr(1, 2);           // k=1
        step(1);            // k=2
        chk("R1 divider not yet active", 32'(cnt_value), 2);
        step(5);            // k=7
        chk("R1 divided hold", 32'(cnt_value), 0);
        step(1);            // k=8
        chk("R1 divided step", 32'(cnt_value), 1);
        wr(4, 1);
        for (int k = 1; k <= 18; k++)
            push("R1 divide by 3", (k / 3) % 5, ((k / 3) % 5) < 2,
                 (k % 15) == 0, (k % 3 == 0) && ((k / 3) % 5 == 2));
        step(18);

        // R8 triangle, limit 3, threshold 2
        wr(1, 0);
        wr(0, cw(1,1,0,0,0,0));
        wr(2, 3);
        wr(4, 1);
        for (int k = 1; k <= 13; k++) begin
            int ph;
            int c;
            ph = k % 6;
            c = (ph <= 3) ? ph : 6 - ph;
            push("R8 triangle", c, c < 2, (ph == 4) || (ph == 1 && k > 1), c == 2);
        end
        step(13);

        // R10 flag and interrupt
        wr(0, cw(1,0,0,0,0,1));
        wr(2, 4);
        wr(4, 1);           // k=0
        chk("R10 flag after update", 32'(upd_flag), 1);
        chk("R10 irq enabled", 32'(irq), 1);
        wr(4, 2);           // k=1
        chk("R10 flag cleared", 32'(upd_flag), 0);
        chk("R10 irq cleared", 32'(irq), 0);
        step(4);            // k=5
        chk("R10 flag on wrap", 32'(upd_flag), 1);
        chk("R2 update pulse on wrap", 32'(upd_pulse), 1);
        step(2);            // k=7
        chk("R10 flag sticky", 32'(upd_flag), 1);
        wr(0, cw(1,0,0,0,0,0));   // k=8
        chk("R10 irq masked", 32'(irq), 0);
        chk("R10 flag kept while masked", 32'(upd_flag), 1);

        // R11 forced update restarts divider phase
        wr(1, 2);
        wr(4, 1);           // k=0, divider now 2
        step(4);
        wr(4, 1);           // k=0 again
        chk("R11 count cleared", 32'(cnt_value), 0);
        step(2);
        chk("R11 phase restarted hold", 32'(cnt_value), 0);
        step(1);
        chk("R11 phase restarted step", 32'(cnt_value), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule